// File: doc/BRIEF.md
# Dual-Channel Compare-Match Interval Timer

This peripheral holds two independent up-counting channels behind a small synchronous register bus. Each channel divides a count-clock tick by a selectable power of two. It counts the divided steps upward, and when the count reaches its compare value it returns to zero. At that point a sticky match flag is set, and the channel raises its interrupt if the interrupt is enabled. The count clock is modelled as the single-cycle enable `tick_en`. A counter therefore advances only in cycles where that enable is high.

A single start register at word address 0 holds one run bit per channel. Software sets the run bit to start a channel and clears it to stop one. Each channel also has a control/status register, a counter register and a compare register. A write to the counter register reaches the counter only on the second count-clock tick after the write. Until then, reads return the old count. The match flag is cleared by writing 0 to its bit position, and writing 1 leaves it unchanged, so software can read the register, mask the flag and write the value back.

Top module: `cmt_timer`

## Requirements
- R1: Bit c of the start register (word address 0, bits [NUM_CH-1:0]) runs channel c when 1. When it is 0, channel c's counter holds its value. The start register changes only on writes to address 0.
- R2: A running channel adds one to its counter on each prescaled step. At a step where the counter equals the compare value, the counter becomes 0, so one period is (compare + 1) × divide count-clock ticks.
- R3: A compare match sets the sticky match flag in bit 7 of the channel's control/status register.
- R4: Writing 0 to bit 7 of the control/status register clears the match flag, and writing 1 leaves it unchanged. If a match and a clearing write happen in the same cycle, the flag ends set.
- R5: Control/status bits [1:0] select the divide: 00 = 8, 01 = 32, 10 = 128, 11 = 512. The value 0x43 gives divide-by-512 with the interrupt enabled. The divider is held at zero while the channel is stopped, so the first step comes a full divide period after start.
- R6: irq[c] goes high one clock after both the match flag and the interrupt enable (control/status bit 6) are high. It stays high until one of them is cleared. Writing 0 to the control/status register drops irq[c].
- R7: A counter write reaches the counter on the second `tick_en` after the write cycle, and reads return the previous value until then. A new counter write restarts this delay.
- R8: The compare register can be rewritten while the channel runs. A counter already above the new compare value counts on to all ones and wraps to 0 without setting the flag.
- R9: The compare register resets to all ones. With all ones as the compare value, the counter matches at its maximum, returns to 0 and sets the flag.
- R10: Channel c sits at word addresses 4c+1 (control/status), 4c+2 (counter) and 4c+3 (compare). Other addresses read 0, and control/status bits other than 7, 6, 1 and 0 read 0. After reset, every register except compare reads 0.
- R11: `bus_rdata` presents, one clock after an address is applied, the addressed register as it stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-clock tick, one cycle wide |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| irq | output | NUM_CH | Per-channel interrupt, level |

## Verification
Directed sequences gate `tick_en` by hand so that each boundary lands on a known tick. These cover the second-tick counter load, the 24-tick period of compare 2 at divide 8 and the 512-tick first step of setting 0x43. They also include a counter sitting above a freshly lowered compare value, which tells a wrap at all ones apart from a premature match. An all-ones compare distinguishes a match at the maximum from a plain overflow, and stopping one channel while the other runs tells per-bit run control apart from a shared gate. A long pseudo-random phase follows, with sparse register writes and irregular ticks, and a behavioural model is compared against read data and interrupts on every clock.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int SEL_W    = 2;
  localparam int SUB_W    = 2;

  typedef logic [SEL_W-1:0] presel_t;

  typedef enum logic [SUB_W-1:0] {
    SUB_SHARED = 2'd0,
    SUB_CSR    = 2'd1,
    SUB_CNT    = 2'd2,
    SUB_CMP    = 2'd3
  } sub_e;

  // log2 of the divide ratio: 8, 32, 128, 512
  function automatic int unsigned div_shift(input presel_t s);
    return 32'd3 + 32'd2 * 32'(s);
  endfunction
endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale #(
  parameter int PRE_W = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            tick,
  input  cmt_pkg::presel_t sel,
  output logic            step
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic             term;

  always_comb begin
    lim  = PRE_W'((32'd1 << cmt_pkg::div_shift(sel)) - 32'd1);
    term = (pre_q >= lim);
  end

  assign step = run & tick & term;

  always_ff @(posedge clk) begin
    if (rst || !run)
      pre_q <= '0;
    else if (tick)
      pre_q <= term ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             csr_we,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] csr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             irq_o
);
  import cmt_pkg::*;

  logic [CNT_W-1:0] cnt_q, cmp_q, pval_q;
  logic             flag_q, ie_q, pend_q, seen_q, irq_q;
  presel_t          sel_q;
  logic             step, load, hit;

  cmt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick),
    .sel (sel_q),
    .step(step)
  );

  assign load = pend_q & seen_q & tick & ~cnt_we;
  assign hit  = step & (cnt_q == cmp_q) & ~load;

  // counter with delayed software load
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      seen_q <= 1'b0;
      pval_q <= '0;
    end else begin
      if (load)
        cnt_q <= pval_q;
      else if (step)
        cnt_q <= (cnt_q == cmp_q) ? '0 : cnt_q + 1'b1;

      if (cnt_we) begin
        pend_q <= 1'b1;
        seen_q <= 1'b0;
        pval_q <= wdata;
      end else if (load) begin
        pend_q <= 1'b0;
        seen_q <= 1'b0;
      end else if (pend_q && tick) begin
        seen_q <= 1'b1;
      end
    end
  end

  // control/status, compare and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '1;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      sel_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= wdata;
      if (hit)
        flag_q <= 1'b1;
      else if (csr_we && !wdata[FLAG_BIT])
        flag_q <= 1'b0;
      if (csr_we) begin
        ie_q  <= wdata[IE_BIT];
        sel_q <= wdata[SEL_W-1:0];
      end
      irq_q <= flag_q & ie_q;
    end
  end

  always_comb begin
    csr_o              = '0;
    csr_o[FLAG_BIT]    = flag_q;
    csr_o[IE_BIT]      = ie_q;
    csr_o[SEL_W-1:0]   = sel_q;
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign irq_o = irq_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q)); // R7
  AST_LOAD_SECOND_TICK: assert property (@(posedge clk) disable iff (rst)
    (pend_q && seen_q && tick && !cnt_we) |=> (cnt_q == $past(pval_q))); // R7
  AST_WRAP_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (step && (cnt_q == cmp_q) && !load) |=> (cnt_q == '0 && flag_q)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(csr_we && !wdata[FLAG_BIT])) |=> flag_q); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(ie_q)); // R6
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 9,
  parameter int ADDR_W = $clog2(4 * NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  import cmt_pkg::*;

  localparam int IDX_W = ADDR_W - SUB_W;

  logic [NUM_CH-1:0] start_q;
  logic [CNT_W-1:0]  csr_w [NUM_CH];
  logic [CNT_W-1:0]  cnt_w [NUM_CH];
  logic [CNT_W-1:0]  cmp_w [NUM_CH];
  logic [CNT_W-1:0]  rd_mux;
  logic [CNT_W-1:0]  rdata_q;
  logic [IDX_W-1:0]  ch_idx;
  sub_e              sub;

  assign ch_idx = bus_addr[ADDR_W-1:SUB_W];
  assign sub    = sub_e'(bus_addr[SUB_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst)
      start_q <= '0;
    else if (bus_we && bus_addr == '0)
      start_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_me;
    assign sel_me = bus_we && (int'(ch_idx) == c);

    cmt_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick_en),
      .run   (start_q[c]),
      .csr_we(sel_me && sub == SUB_CSR),
      .cnt_we(sel_me && sub == SUB_CNT),
      .cmp_we(sel_me && sub == SUB_CMP),
      .wdata (bus_wdata),
      .csr_o (csr_w[c]),
      .cnt_o (cnt_w[c]),
      .cmp_o (cmp_w[c]),
      .irq_o (irq[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (sub == SUB_SHARED) begin
      if (ch_idx == '0) rd_mux = CNT_W'(start_q);
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (int'(ch_idx) == c) begin
          case (sub)
            SUB_CSR: rd_mux = csr_w[c];
            SUB_CNT: rd_mux = cnt_w[c];
            SUB_CMP: rd_mux = cmp_w[c];
            default: rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  AST_START_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (!bus_we || bus_addr != '0) |=> $stable(start_q)); // R1
endmodule

// File: tb/sim_cmt_timer.sv
module sim_cmt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NCH = 2;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [NCH-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmt_timer #(.NUM_CH(NCH), .CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  int m_cnt[NCH], m_cmp[NCH], m_ie[NCH], m_sel[NCH], m_flag[NCH];
  int m_pre[NCH], m_pend[NCH], m_pval[NCH], m_seen[NCH];
  int m_start, m_rdata, m_irq[NCH];

  function automatic int m_read(input int a);
    int c, s;
    c = a / 4; s = a % 4;
    if (s == 0) return (c == 0) ? m_start : 0;
    if (c >= NCH) return 0;
    if (s == 1) return (m_flag[c] << 7) | (m_ie[c] << 6) | m_sel[c];
    if (s == 2) return m_cnt[c];
    return m_cmp[c];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_start = 0; m_rdata = 0;
      for (int c = 0; c < NCH; c++) begin
        m_cnt[c] = 0; m_cmp[c] = MASK; m_ie[c] = 0; m_sel[c] = 0; m_flag[c] = 0;
        m_pre[c] = 0; m_pend[c] = 0; m_pval[c] = 0; m_seen[c] = 0; m_irq[c] = 0;
      end
    end else begin
      m_rdata = m_read(int'(bus_addr));
      for (int c = 0; c < NCH; c++) begin
        int lim, run, stp, ld, hit, wc, wn, wp, t;
        t    = int'(tick_en);
        m_irq[c] = m_flag[c] & m_ie[c];
        lim  = (1 << (3 + 2 * m_sel[c])) - 1;
        run  = (m_start >> c) & 1;
        stp  = run && t && (m_pre[c] >= lim);
        wc   = bus_we && (int'(bus_addr) == 4*c + 1);
        wn   = bus_we && (int'(bus_addr) == 4*c + 2);
        wp   = bus_we && (int'(bus_addr) == 4*c + 3);
        ld   = m_pend[c] && m_seen[c] && t && !wn;
        hit  = stp && (m_cnt[c] == m_cmp[c]) && !ld;
        if (!run) m_pre[c] = 0;
        else if (t) m_pre[c] = (m_pre[c] >= lim) ? 0 : m_pre[c] + 1;
        if (ld) m_cnt[c] = m_pval[c];
        else if (stp) m_cnt[c] = (m_cnt[c] == m_cmp[c]) ? 0 : ((m_cnt[c] + 1) & MASK);
        if (wn) begin m_pend[c] = 1; m_seen[c] = 0; m_pval[c] = int'(bus_wdata); end
        else if (ld) begin m_pend[c] = 0; m_seen[c] = 0; end
        else if (m_pend[c] && t) m_seen[c] = 1;
        if (hit) m_flag[c] = 1;
        else if (wc && !bus_wdata[7]) m_flag[c] = 0;
        if (wc) begin m_ie[c] = int'(bus_wdata[6]); m_sel[c] = int'(bus_wdata[1:0]); end
        if (wp) m_cmp[c] = int'(bus_wdata);
      end
      if (bus_we && bus_addr == 3'd0) m_start = int'(bus_wdata) & ((1 << NCH) - 1);
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (int'(bus_rdata) != m_rdata) begin
        errors++;
        $display("FAIL R11 rdata actual=%h expected=%h", bus_rdata, m_rdata[W-1:0]);
      end
      for (int c = 0; c < NCH; c++) begin
        checks++;
        if (int'(irq[c]) != m_irq[c]) begin
          errors++;
          $display("FAIL R6 irq[%0d] actual=%0d expected=%0d", c, irq[c], m_irq[c]);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input logic w, input logic [2:0] a, input logic [W-1:0] d, input logic t);
    bus_we = w; bus_addr = a; bus_wdata = d; tick_en = t;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd4, '0, 1'b1);
  endtask

  task automatic chk(input string tag, input logic [2:0] a, input int exp);
    cyc(1'b0, a, '0, 1'b0);
    checks++;
    if (int'(bus_rdata) != exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp[W-1:0]);
    end
  endtask

  task automatic chk_irq(input string tag, input int c, input int exp);
    checks++;
    if (int'(irq[c]) != exp) begin
      errors++;
      $display("FAIL %s irq[%0d] actual=%0d expected=%0d", tag, c, irq[c], exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // reset state
    chk("R10 reset start", 3'd0, 0);
    chk("R10 reset csr0", 3'd1, 0);
    chk("R10 reset cnt0", 3'd2, 0);
    chk("R9 reset cmp0", 3'd3, 16'hFFFF);
    chk("R10 reserved", 3'd4, 0);
    chk("R9 reset cmp1", 3'd7, 16'hFFFF);
    chk_irq("R6 reset", 0, 0);

    // R7: delayed counter load on a stopped channel
    wr(3'd2, 16'h1234);
    chk("R7 no tick yet", 3'd2, 0);
    pulse(1);
    chk("R7 one tick", 3'd2, 0);
    pulse(1);
    chk("R7 two ticks", 3'd2, 16'h1234);
    chk("R10 ch1 cnt untouched", 3'd6, 0);

    // R2 R3 R6: period of compare 2 at divide 8
    wr(3'd2, 16'h0000); pulse(2);
    chk("R7 cleared", 3'd2, 0);
    wr(3'd3, 16'd2);
    wr(3'd1, 16'h0040);
    wr(3'd0, 16'h0001);
    pulse(23);
    chk("R2 before match cnt", 3'd2, 2);
    chk("R3 before match flag", 3'd1, 16'h0040);
    pulse(1);
    chk("R2 wrap to zero", 3'd2, 0);
    chk("R3 flag set", 3'd1, 16'h00C0);
    chk_irq("R6 irq raised", 0, 1);

    // R4: write 1 keeps, write 0 clears
    wr(3'd1, 16'h00C0);
    chk("R4 write one keeps", 3'd1, 16'h00C0);
    wr(3'd1, 16'h0040);
    chk("R4 write zero clears", 3'd1, 16'h0040);
    chk_irq("R6 irq dropped", 0, 0);

    // R6 R10: interrupt disabled, unused bits
    pulse(24);
    wr(3'd1, 16'h0080);
    chk("R6 ie off flag kept", 3'd1, 16'h0080);
    chk_irq("R6 irq masked", 0, 0);
    wr(3'd1, 16'h00BC);
    chk("R10 unused csr bits", 3'd1, 16'h0080);
    wr(3'd1, 16'h0000);
    chk("R6 csr cleared", 3'd1, 0);

    // R1: per-channel run bits
    wr(3'd0, 16'h0003);
    chk("R1 start readback", 3'd0, 3);
    pulse(8);
    chk("R1 ch0 runs", 3'd2, 1);
    chk("R1 ch1 runs", 3'd6, 1);
    wr(3'd0, 16'h0002);
    pulse(8);
    chk("R1 ch0 frozen", 3'd2, 1);
    chk("R1 ch1 continues", 3'd6, 2);

    // R5: 0x43 selects divide 512
    wr(3'd0, 16'h0000);
    wr(3'd6, 16'h0000); pulse(2);
    wr(3'd5, 16'h0043);
    chk("R5 csr 0x43", 3'd5, 16'h0043);
    wr(3'd0, 16'h0002);
    pulse(511);
    chk("R5 before 512", 3'd6, 0);
    pulse(1);
    chk("R5 at 512", 3'd6, 1);

    // R8: compare lowered below the count
    wr(3'd0, 16'h0000);
    wr(3'd6, 16'hFFFE); pulse(2);
    wr(3'd5, 16'h0040);
    wr(3'd7, 16'd2);
    wr(3'd0, 16'h0002);
    pulse(8);
    chk("R8 count to max", 3'd6, 16'hFFFF);
    pulse(8);
    chk("R8 wrapped", 3'd6, 0);
    chk("R8 no flag on wrap", 3'd5, 16'h0040);
    pulse(16);
    chk("R8 count 2", 3'd6, 2);
    pulse(8);
    chk("R8 match new cmp", 3'd5, 16'h00C0);

    // R9: all-ones compare matches at maximum
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'h0040);
    wr(3'd7, 16'hFFFF);
    wr(3'd6, 16'hFFFF); pulse(2);
    wr(3'd0, 16'h0002);
    pulse(8);
    chk("R9 max wraps", 3'd6, 0);
    chk("R9 max sets flag", 3'd5, 16'h00C0);

    // pseudo-random phase, checked every clock against the model
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 8000; i++) begin
      logic w;
      logic [2:0] a;
      logic [W-1:0] d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      w = (lfsr[4:2] == 3'd0);
      a = lfsr[10:8];
      d = lfsr[27:12];
      if (a[1:0] == 2'd2 || a[1:0] == 2'd3) d = d & 16'h001F;
      if (a[1:0] == 2'd1) d[1] = 1'b0;
      cyc(w, a, d, lfsr[15] | lfsr[16]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule